// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block

This block gathers event pulses from a peripheral into a latched status register, qualifies them with a per-source enable register and a single global enable bit, and drives one level-sensitive interrupt line. Software uses a small register bus to reach the three registers. That bus carries a word address, a write strobe, write data and combinational read data. Software uses the status register both to set bits and to acknowledge them, because writing a one to a status bit inverts that bit.

The parameter `NUM_IRQ` (0 to 32) sets how many sources exist. The implemented sources sit at the top of the 32-bit word: the first is bit 31 and the rest follow toward bit 0. Every other position reads as zero. The parameter `STS_RST` gives each status bit its own reset value. Sources that come out of reset set are therefore visible to software at once.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable register and the global enable read 0, the status register reads `STS_RST` restricted to implemented bits, and `irq_o` is 0.
- R2: Bits 31 down to 32-`NUM_IRQ` are implemented. Every other bit position reads 0 in every register, ignores writes and ignores events.
- R3: A write to the status register (address 0) inverts each implemented bit written with 1 and leaves bits written with 0 unchanged. The new value is readable in the cycle after the write.
- R4: A one-cycle high pulse on `evt_i` at an implemented bit sets that status bit. The bit then holds until software toggles it.
- R5: When an event and a status toggle hit the same bit in the same cycle, that bit ends at 1.
- R6: A write to the enable register (address 1) replaces its contents. Writing zero disables every source.
- R7: The global enable is bit 0 of address 2. While it is 0, `irq_o` is 0.
- R8: `irq_o` is a register holding the OR of status AND enable, gated by the global enable. It reflects a state change one clock after the state changes.
- R9: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address: 0 status, 1 enable, 2 global enable, 3 reserved |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| evt_i | input | 32 | Event pulses, one per bit position, aligned with the status register |
| irq_o | output | 1 | Interrupt output, registered |

## Verification
A corrupted status or enable bit appears at `rd_data_o` as soon as software reads that address. The same fault appears on `irq_o` exactly one clock after it starts, provided the global enable is on and the bit is enabled. A wrong global enable shows on `irq_o` within one clock whenever any source is pending. The bench checks the interrupt line in both the cycle before and the cycle after each state change, so a missing or extra register stage is caught.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STS = 2'd0,
    SEL_EN  = 2'd1,
    SEL_GIE = 2'd2,
    SEL_RSV = 2'd3
  } reg_sel_e;

  // implemented positions packed from the MSB downward
  function automatic logic [DATA_W-1:0] impl_mask(int unsigned n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++)
      if (i < n) m[DATA_W-1-i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_sts_reg.sv
module irq_sts_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned      NUM_IRQ = 8,
  parameter logic [DATA_W-1:0] STS_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tgl_i,
  input  logic [DATA_W-1:0] evt_i,
  output logic [DATA_W-1:0] sts_o
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_IRQ);

  logic [DATA_W-1:0] sts_q, sts_d;

  // event wins over a simultaneous toggle
  assign sts_d = ((sts_q ^ tgl_i) | evt_i) & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= STS_RST & MASK;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              gie_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] en_o,
  output logic              gie_o
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_IRQ);

  logic [DATA_W-1:0] en_q;
  logic              gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (en_we_i)  en_q  <= wr_data_i & MASK;
      if (gie_we_i) gie_q <= wr_data_i[0];
    end
  end

  assign en_o  = en_q;
  assign gie_o = gie_q;
endmodule

// File: rtl/irq_out.sv
module irq_out
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sts_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic              gie_i,
  output logic              irq_o
);
  logic any_pend;
  logic irq_q;

  if (NUM_IRQ == 0) begin : g_none
    assign any_pend = 1'b0;
  end else begin : g_some
    assign any_pend = |(sts_i & en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= gie_i & any_pend;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned      NUM_IRQ = 8,
  parameter logic [DATA_W-1:0] STS_RST = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] evt_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_IRQ);

  reg_sel_e          sel;
  logic [DATA_W-1:0] sts_q, en_q, tgl;
  logic              gie_q;

  assign sel = reg_sel_e'(addr_i);
  assign tgl = (wr_en_i && sel == SEL_STS) ? (wr_data_i & MASK) : '0;

  irq_sts_reg #(.NUM_IRQ(NUM_IRQ), .STS_RST(STS_RST)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tgl_i (tgl),
    .evt_i (evt_i & MASK),
    .sts_o (sts_q)
  );

  irq_en_reg #(.NUM_IRQ(NUM_IRQ)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_we_i  (wr_en_i && sel == SEL_EN),
    .gie_we_i (wr_en_i && sel == SEL_GIE),
    .wr_data_i(wr_data_i),
    .en_o     (en_q),
    .gie_o    (gie_q)
  );

  irq_out #(.NUM_IRQ(NUM_IRQ)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sts_i (sts_q),
    .en_i  (en_q),
    .gie_i (gie_q),
    .irq_o (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STS: rd_data_o = sts_q;
      SEL_EN:  rd_data_o = en_q;
      SEL_GIE: rd_data_o = {{(DATA_W-1){1'b0}}, gie_q};
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] evt_i,
  input logic [DATA_W-1:0] sts_q,
  input logic [DATA_W-1:0] en_q,
  input logic              gie_q,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_IRQ);

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q | en_q) & ~MASK) == '0); // R2

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & MASK)) |=> ((sts_q & $past(evt_i & MASK)) == $past(evt_i & MASK))); // R5

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> en_q == ($past(wr_data_i) & MASK)); // R6

  AST_GIE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |=> !irq_o); // R7

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_q && |(sts_q & en_q)) |=> irq_o); // R8

  AST_RSV_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3 && (evt_i & MASK) == '0) |=>
      ($stable(sts_q) && $stable(en_q) && $stable(gie_q))); // R9
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wr_data_i(wr_data_i),
  .evt_i    (evt_i),
  .sts_q    (sts_q),
  .en_q     (en_q),
  .gie_q    (gie_q),
  .irq_o    (irq_o)
);

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [31:0] evt_i = '0;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .evt_i(evt_i), .irq_o(irq_o)
  );

  // monitor: compares away from the active edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq_o} : rd_data_o;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [31:0] e);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d; evt_i = e;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(posedge clk_i); #1;
    evt_i = e;
    @(posedge clk_i); #1;
    evt_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    addr_i = a;
    it.exp = exp; it.is_irq = 0; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
    @(posedge clk_i); #1;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    item_t it;
    it.exp = {31'd0, exp}; it.is_irq = 1; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
    @(posedge clk_i); #1;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, 32'h0100_0000, "R1 status reset");
    rd(2'd1, 32'h0, "R1 enable reset");
    rd(2'd2, 32'h0, "R1 gie reset");
    chk_irq(1'b0, "R1 irq reset");
    // R3 toggle, R2 low bits ignored
    wr(2'd0, 32'hFFFF_FFFF, 32'h0);
    rd(2'd0, 32'hFE00_0000, "R3 toggle all / R2 low bits");
    wr(2'd0, 32'hFE00_0000, 32'h0);
    rd(2'd0, 32'h0, "R3 second toggle clears");
    // R6 enable replace, R2 mask
    wr(2'd1, 32'hFFFF_FFFF, 32'h0);
    rd(2'd1, 32'hFF00_0000, "R6 enable load / R2");
    chk_irq(1'b0, "R8 no pending");
    // R4 event sets; R7 gated
    pulse(32'h1000_0000);
    rd(2'd0, 32'h1000_0000, "R4 event sets");
    chk_irq(1'b0, "R7 gie off gates");
    rd(2'd0, 32'h1000_0000, "R4 holds");
    // R7/R8 global enable on, one clock latency
    wr(2'd2, 32'h0000_0001, 32'h0);
    chk_irq(1'b0, "R8 before latency");
    chk_irq(1'b1, "R8 after latency");
    rd(2'd2, 32'h1, "R7 gie readback");
    // R6 enable zero disables
    wr(2'd1, 32'h0, 32'h0);
    chk_irq(1'b1, "R8 old value one cycle");
    chk_irq(1'b0, "R6 zero disables");
    wr(2'd1, 32'h1000_0000, 32'h0);
    chk_irq(1'b0, "R8 latency re-enable");
    chk_irq(1'b1, "R8 re-enabled");
    wr(2'd2, 32'h0, 32'h0);
    chk_irq(1'b1, "R7 old value one cycle");
    chk_irq(1'b0, "R7 gie off forces low");
    // R5 event and toggle together
    wr(2'd0, 32'h4000_0000, 32'h0);
    rd(2'd0, 32'h5000_0000, "R3 set bit30");
    wr(2'd0, 32'h4000_0000, 32'h4000_0000);
    rd(2'd0, 32'h5000_0000, "R5 event wins");
    // R9 reserved address
    wr(2'd3, 32'hFFFF_FFFF, 32'h0);
    rd(2'd3, 32'h0, "R9 reserved reads zero");
    rd(2'd0, 32'h5000_0000, "R9 status untouched");
    rd(2'd1, 32'h1000_0000, "R9 enable untouched");
    rd(2'd2, 32'h0, "R9 gie untouched");
    // R2 event on unimplemented bit
    pulse(32'h00FF_FFFF);
    rd(2'd0, 32'h5000_0000, "R2 low events ignored");
    repeat (2) @(posedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule